// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 32-bit virtual address into a 36-bit physical address by walking translation tables held in memory. A walk starts from a context-table pointer and a context number, then follows pointer entries through up to three table levels. Any level past the context table may end the walk early with a page entry, so a translation maps a 16 MB, 256 KB or 4 KB page. The result comes back with a one-cycle done pulse. It carries the physical address, a page-size code and an error code that records both the level the walk reached and the kind of fault.

When the page entry passes the external permission check, the walker keeps its referenced and modified flags current. If a flag must change, it writes the updated entry back to the same word. A bypass input skips translation altogether. In that case instruction fetches can be sent to a boot ROM window while a boot flag is set. A probe request walks toward a chosen level and returns the raw entry found there, without any writeback or fault.

The walker reaches memory through a single 32-bit request/grant port that allows one read in flight. Read data comes back on a separate valid strobe.

Top module: `ptw_walker`

## Requirements
- R1: After reset `req_ready_o` is 1, `done_o` is 0 and `mem_req_o` is 0.
- R2: The first read goes to `{ctp_i,4'b0} + ctx_i*4`. A pointer entry (type 1) gives the next table base `{entry[31:2],6'b0}`. The index added to that base is VA[31:24]*4 for level 1, VA[23:18]*4 for level 2 and VA[17:12]*4 for level 3.
- R3: Entry type is entry[1:0], with 0 invalid, 1 pointer, 2 page and 3 reserved. `err_o[9:8]` holds the level (0 = context table, 1 to 3 = table levels) and `err_o[4:2]` holds the fault type: 1 for invalid, 4 for translation error. All other bits of `err_o` are zero, and `err_o` is zero on success.
- R4: The walk ends with fault type 4 on a reserved entry at any level, on a page entry in the context table, and on a pointer at level 3.
- R5: A page entry at level 1, 2 or 3 sets `size_o` to 2 (16 MB), 1 (256 KB) or 0 (4 KB). `pa_o` is `{entry[31:8],12'b0}` plus VA[23:0], VA[17:0] or VA[11:0] respectively. `rights_o` is 0 and `pte_o` is the entry after any flag update.
- R6: While a page entry waits for the permission verdict, `chk_valid_o` is 1 and `chk_pte_o` is that entry. A nonzero `chk_fault_i` ends the walk with that fault type and the current level in `err_o`, and no write is made.
- R7: After a passed check, if the referenced bit (bit 5) is clear, or the access is a store and the modified bit (bit 6) is clear, the walker writes the entry back to its own address. The written entry has bit 5 set, and also bit 6 for a store.
- R8: No write is made when bit 5 is set and the access is a load, or when bits 5 and 6 are both set.
- R9: `mem_req_o`, `mem_we_o` and `mem_addr_o` hold until `mem_gnt_i`. No new request is raised while a granted read waits for `mem_rvalid_i`.
- R10: With `bypass_i` set, the walker makes no memory access. `pa_o` is the zero-extended VA and `rights_o` is 3'b111, coded {execute, write, read}.
- R11: In bypass, a fetch (`req_fetch_i`) with `boot_i` set gives `pa_o = rom_base_i | VA[18:0]` and `rights_o` = 3'b101.
- R12: A probe with target level L (0 to 3) returns in `pte_o`, with `err_o` 0, one of three values. It gives the pointer or page entry read at level L. It gives a page entry met at a lower table level. It gives 0 for an invalid or reserved entry, a context-level page entry, or a level-3 pointer.
- R13: `done_o` lasts exactly one cycle. `req_ready_o` is 1 only when the walker is idle, and a request is taken on the edge where both `req_valid_i` and `req_ready_o` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request taken |
| req_va_i | input | 32 | Virtual address |
| req_store_i | input | 1 | Access is a store |
| req_fetch_i | input | 1 | Access is an instruction fetch |
| req_probe_i | input | 1 | Probe instead of translate |
| req_level_i | input | 2 | Probe target level |
| ctp_i | input | 32 | Context-table pointer |
| ctx_i | input | CTX_W | Context number |
| bypass_i | input | 1 | Translation bypassed |
| boot_i | input | 1 | Boot-mode fetch redirect enable |
| rom_base_i | input | 36 | Boot ROM base address |
| mem_req_o | output | 1 | Memory request |
| mem_gnt_i | input | 1 | Memory request accepted |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 36 | Word byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| chk_valid_o | output | 1 | Page entry awaiting permission verdict |
| chk_pte_o | output | 32 | Entry under check |
| chk_fault_i | input | 3 | Permission fault type, 0 passes |
| done_o | output | 1 | Result valid pulse |
| pa_o | output | 36 | Physical address |
| size_o | output | 2 | Page size code |
| err_o | output | 10 | Level and fault code |
| pte_o | output | 32 | Final or probed entry |
| rights_o | output | 3 | Bypass rights {x,w,r} |

## Verification
The assertions take three things for granted about the environment. The memory returns exactly one `mem_rvalid_i` for each granted read, never without a pending read. `chk_fault_i` is a combinational verdict that stays steady while `chk_valid_o` is high. Requests arrive only when `req_ready_o` is seen high. The bench keeps within these rules. Its memory model holds one read at a time, and it varies grant and read latency from a shift register. It sets the verdict before each request, holds it until done, and drives each request for a single accepted cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W  = 32;
  localparam int PA_W  = 36;
  localparam int PTE_W = 32;
  localparam int ERR_W = 10;
  localparam int L1_LSB = 24;
  localparam int L2_LSB = 18;
  localparam int L3_LSB = 12;
  localparam int REF_BIT = 5;
  localparam int MOD_BIT = 6;
  localparam int ROM_W = 19;

  localparam logic [2:0] FT_INVALID = 3'd1;
  localparam logic [2:0] FT_XLATE   = 3'd4;

  localparam logic [1:0] SZ_4K   = 2'd0;
  localparam logic [1:0] SZ_256K = 2'd1;
  localparam logic [1:0] SZ_16M  = 2'd2;

  typedef enum logic [1:0] {ET_INVALID = 2'd0, ET_PTD = 2'd1, ET_PTE = 2'd2, ET_RSVD = 2'd3} etype_e;
  typedef enum logic [1:0] {A_DESCEND, A_LEAF, A_FAULT, A_PROBE} act_e;
  typedef enum logic [2:0] {S_IDLE, S_RD_REQ, S_RD_WAIT, S_CHECK, S_WB, S_DONE} state_e;

  function automatic logic [ERR_W-1:0] mk_err(input logic [1:0] lvl, input logic [2:0] ft);
    return {lvl, 3'b000, ft, 2'b00};
  endfunction
endpackage

// File: rtl/ptw_tbl_addr.sv
module ptw_tbl_addr
  import ptw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic [1:0]        lvl_i,
  input  logic [PTE_W-1:0]  ctp_i,
  input  logic [CTX_W-1:0]  ctx_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [PTE_W-3:0]  ptd_i,
  output logic [PA_W-1:0]   addr_o
);
  localparam int IDX_W = VA_W - L1_LSB;
  localparam int NXT_W = L1_LSB - L2_LSB;

  logic [PA_W-1:0]  base;
  logic [PA_W-1:0]  offs;
  logic [IDX_W-1:0] idx;

  always_comb begin
    idx = '0;
    unique case (lvl_i)
      2'd1:    idx = va_i[VA_W-1:L1_LSB];
      2'd2:    idx = {{(IDX_W-NXT_W){1'b0}}, va_i[L1_LSB-1:L2_LSB]};
      default: idx = {{(IDX_W-NXT_W){1'b0}}, va_i[L2_LSB-1:L3_LSB]};
    endcase
    if (lvl_i == 2'd0) begin
      base = {ctp_i, 4'b0000};
      offs = {{(PA_W-CTX_W-2){1'b0}}, ctx_i, 2'b00};
    end else begin
      base = {ptd_i, 6'b000000};
      offs = {{(PA_W-IDX_W-2){1'b0}}, idx, 2'b00};
    end
  end

  assign addr_o = base + offs;
endmodule

// File: rtl/ptw_classify.sv
module ptw_classify
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0] ent_i,
  input  logic [1:0]       lvl_i,
  input  logic             probe_i,
  input  logic [1:0]       plevel_i,
  output act_e             act_o,
  output logic [2:0]       ft_o,
  output logic [PTE_W-1:0] pres_o
);
  etype_e et;
  logic   can_descend;
  logic   leaf_ok;

  assign et          = etype_e'(ent_i[1:0]);
  assign can_descend = (et == ET_PTD) && (lvl_i != 2'd3);
  assign leaf_ok     = (et == ET_PTE) && (lvl_i != 2'd0);

  always_comb begin
    act_o  = A_FAULT;
    ft_o   = FT_XLATE;
    pres_o = '0;
    if (probe_i) begin
      act_o = A_PROBE;
      if (leaf_ok) pres_o = ent_i;
      else if (can_descend) begin
        if (lvl_i == plevel_i) pres_o = ent_i;
        else act_o = A_DESCEND;
      end
    end else if (et == ET_INVALID) begin
      ft_o = FT_INVALID;
    end else if (can_descend) begin
      act_o = A_DESCEND;
    end else if (leaf_ok) begin
      act_o = A_LEAF;
    end
  end
endmodule

// File: rtl/ptw_pa_compose.sv
module ptw_pa_compose
  import ptw_pkg::*;
(
  input  logic [VA_W-1:0]   va_i,
  input  logic [PTE_W-9:0]  ppn_i,
  input  logic [1:0]        lvl_i,
  output logic [PA_W-1:0]   pa_o,
  output logic [1:0]        size_o
);
  logic [PA_W-1:0] offs;

  always_comb begin
    unique case (lvl_i)
      2'd1: begin
        offs   = {{(PA_W-L1_LSB){1'b0}}, va_i[L1_LSB-1:0]};
        size_o = SZ_16M;
      end
      2'd2: begin
        offs   = {{(PA_W-L2_LSB){1'b0}}, va_i[L2_LSB-1:0]};
        size_o = SZ_256K;
      end
      default: begin
        offs   = {{(PA_W-L3_LSB){1'b0}}, va_i[L3_LSB-1:0]};
        size_o = SZ_4K;
      end
    endcase
  end

  assign pa_o = {ppn_i, 12'h000} + offs;
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [VA_W-1:0]     req_va_i,
  input  logic                req_store_i,
  input  logic                req_fetch_i,
  input  logic                req_probe_i,
  input  logic [1:0]          req_level_i,
  input  logic [PTE_W-1:0]    ctp_i,
  input  logic [CTX_W-1:0]    ctx_i,
  input  logic                bypass_i,
  input  logic                boot_i,
  input  logic [PA_W-1:0]     rom_base_i,
  output logic                mem_req_o,
  input  logic                mem_gnt_i,
  output logic                mem_we_o,
  output logic [PA_W-1:0]     mem_addr_o,
  output logic [PTE_W-1:0]    mem_wdata_o,
  input  logic                mem_rvalid_i,
  input  logic [PTE_W-1:0]    mem_rdata_i,
  output logic                chk_valid_o,
  output logic [PTE_W-1:0]    chk_pte_o,
  input  logic [2:0]          chk_fault_i,
  output logic                done_o,
  output logic [PA_W-1:0]     pa_o,
  output logic [1:0]          size_o,
  output logic [ERR_W-1:0]    err_o,
  output logic [PTE_W-1:0]    pte_o,
  output logic [2:0]          rights_o
);
  state_e           state_q;
  logic [1:0]       lvl_q, plevel_q, lvl_sel;
  logic [VA_W-1:0]  va_q;
  logic             store_q, probe_q;
  logic [PA_W-1:0]  addr_q, pa_q, tbl_addr, pa_c;
  logic [PTE_W-1:0] ent_q, pte_q, ent_upd, pres;
  logic [1:0]       size_q, size_c;
  logic [ERR_W-1:0] err_q;
  logic [2:0]       rights_q, ft;
  act_e             act;
  logic             redirect;

  assign lvl_sel  = (state_q == S_IDLE) ? 2'd0 : lvl_q + 2'd1;
  assign redirect = req_fetch_i && boot_i;
  assign ent_upd  = ent_q | (PTE_W'(1) << REF_BIT) | (store_q ? (PTE_W'(1) << MOD_BIT) : '0);

  ptw_tbl_addr #(.CTX_W(CTX_W)) u_tbl_addr (
    .lvl_i  (lvl_sel),
    .ctp_i  (ctp_i),
    .ctx_i  (ctx_i),
    .va_i   (va_q),
    .ptd_i  (mem_rdata_i[PTE_W-1:2]),
    .addr_o (tbl_addr)
  );

  ptw_classify u_classify (
    .ent_i    (mem_rdata_i),
    .lvl_i    (lvl_q),
    .probe_i  (probe_q),
    .plevel_i (plevel_q),
    .act_o    (act),
    .ft_o     (ft),
    .pres_o   (pres)
  );

  ptw_pa_compose u_pa (
    .va_i   (va_q),
    .ppn_i  (ent_q[PTE_W-1:8]),
    .lvl_i  (lvl_q),
    .pa_o   (pa_c),
    .size_o (size_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      lvl_q    <= '0;
      plevel_q <= '0;
      va_q     <= '0;
      store_q  <= 1'b0;
      probe_q  <= 1'b0;
      addr_q   <= '0;
      ent_q    <= '0;
      pa_q     <= '0;
      size_q   <= SZ_4K;
      err_q    <= '0;
      pte_q    <= '0;
      rights_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          store_q  <= req_store_i;
          probe_q  <= req_probe_i;
          plevel_q <= req_level_i;
          err_q    <= '0;
          pte_q    <= '0;
          size_q   <= SZ_4K;
          rights_q <= '0;
          if (bypass_i) begin
            pa_q     <= redirect ? (rom_base_i | {{(PA_W-ROM_W){1'b0}}, req_va_i[ROM_W-1:0]})
                                 : {{(PA_W-VA_W){1'b0}}, req_va_i};
            rights_q <= redirect ? 3'b101 : 3'b111;
            state_q  <= S_DONE;
          end else begin
            va_q    <= req_va_i;
            pa_q    <= '0;
            addr_q  <= tbl_addr;
            lvl_q   <= 2'd0;
            state_q <= S_RD_REQ;
          end
        end
        S_RD_REQ: if (mem_gnt_i) state_q <= S_RD_WAIT;
        S_RD_WAIT: if (mem_rvalid_i) begin
          unique case (act)
            A_DESCEND: begin
              addr_q  <= tbl_addr;
              lvl_q   <= lvl_q + 2'd1;
              state_q <= S_RD_REQ;
            end
            A_LEAF: begin
              ent_q   <= mem_rdata_i;
              state_q <= S_CHECK;
            end
            A_PROBE: begin
              pte_q   <= pres;
              state_q <= S_DONE;
            end
            default: begin
              err_q   <= mk_err(lvl_q, ft);
              state_q <= S_DONE;
            end
          endcase
        end
        S_CHECK: begin
          if (chk_fault_i != 3'd0) begin
            err_q   <= mk_err(lvl_q, chk_fault_i);
            state_q <= S_DONE;
          end else begin
            pa_q   <= pa_c;
            size_q <= size_c;
            pte_q  <= ent_upd;
            if (ent_upd != ent_q) begin
              ent_q   <= ent_upd;
              state_q <= S_WB;
            end else begin
              state_q <= S_DONE;
            end
          end
        end
        S_WB: if (mem_gnt_i) state_q <= S_DONE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign mem_req_o   = (state_q == S_RD_REQ) || (state_q == S_WB);
  assign mem_we_o    = (state_q == S_WB);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = ent_q;
  assign chk_valid_o = (state_q == S_CHECK);
  assign chk_pte_o   = ent_q;
  assign done_o      = (state_q == S_DONE);
  assign pa_o        = pa_q;
  assign size_o      = size_q;
  assign err_o       = err_q;
  assign pte_o       = pte_q;
  assign rights_o    = rights_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
  import ptw_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              done_o,
  input logic [ERR_W-1:0]  err_o,
  input logic              mem_req_o,
  input logic              mem_gnt_i,
  input logic              mem_we_o,
  input logic [PA_W-1:0]   mem_addr_o,
  input logic [PTE_W-1:0]  mem_wdata_o,
  input logic              mem_rvalid_i,
  input logic              chk_valid_o,
  input logic [2:0]        chk_fault_i
);
  logic rd_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_pend_q <= 1'b0;
    else if (mem_req_o && mem_gnt_i && !mem_we_o) rd_pend_q <= 1'b1;
    else if (mem_rvalid_i) rd_pend_q <= 1'b0;
  end

  a_r9_hold_until_gnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  a_r9_one_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pend_q |-> !mem_req_o);

  a_r13_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r13_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o && !done_o && !chk_valid_o);

  a_r7_wb_sets_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o[REF_BIT] && (mem_wdata_o[1:0] == 2'b10));

  a_r3_err_layout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (err_o[7:5] == 3'b000) && (err_o[1:0] == 2'b00));

  a_r6_fault_no_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_o && (chk_fault_i != 3'd0) |=> !mem_req_o && done_o);
endmodule

bind ptw_walker ptw_walker_chk u_ptw_walker_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .mem_req_o    (mem_req_o),
  .mem_gnt_i    (mem_gnt_i),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_rvalid_i (mem_rvalid_i),
  .chk_valid_o  (chk_valid_o),
  .chk_fault_i  (chk_fault_i)
);

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, req_ready, req_store = 1'b0, req_fetch = 1'b0, req_probe = 1'b0;
  logic [1:0]  req_level = '0;
  logic [31:0] req_va = '0, ctp = 32'h0010_0000;
  logic [7:0]  ctx = '0;
  logic        bypass = 1'b0, boot = 1'b0;
  logic [35:0] rom_base = 36'hF_F000_0000;
  logic        mem_req, mem_gnt = 1'b0, mem_we, mem_rvalid = 1'b0;
  logic [35:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic        chk_valid;
  logic [31:0] chk_pte;
  logic [2:0]  chk_fault = '0;
  logic        done;
  logic [35:0] pa;
  logic [1:0]  size;
  logic [9:0]  err;
  logic [31:0] pte;
  logic [2:0]  rights;

  ptw_walker uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
    .req_store_i(req_store), .req_fetch_i(req_fetch), .req_probe_i(req_probe),
    .req_level_i(req_level), .ctp_i(ctp), .ctx_i(ctx), .bypass_i(bypass),
    .boot_i(boot), .rom_base_i(rom_base),
    .mem_req_o(mem_req), .mem_gnt_i(mem_gnt), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .chk_valid_o(chk_valid), .chk_pte_o(chk_pte), .chk_fault_i(chk_fault),
    .done_o(done), .pa_o(pa), .size_o(size), .err_o(err), .pte_o(pte), .rights_o(rights)
  );

  int checks = 0, errors = 0, cycles = 0;

  typedef struct { bit we; bit [35:0] addr; bit [31:0] data; string tag; } acc_t;
  acc_t exp_q[$];
  bit [31:0] mem [bit [35:0]];
  bit [31:0] exp_leaf;
  bit        exp_leaf_v;

  function automatic bit [31:0] rd(bit [35:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // memory model: random grant, one read in flight, 0..3 cycles read latency
  bit [15:0] lf = 16'hACE1;
  bit        rpend = 0;
  bit [1:0]  rwait = 0;
  bit [35:0] raddr = 0;
  always @(posedge clk) begin
    lf <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    mem_gnt <= lf[1] | lf[4];
    mem_rvalid <= 1'b0;
    if (rpend) begin
      if (rwait == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= rd(raddr);
        rpend      <= 0;
      end else rwait <= rwait - 2'd1;
    end
    if (rst_n && mem_req && mem_gnt) begin
      if (mem_we) mem[mem_addr] = mem_wdata;
      else begin
        rpend <= 1;
        rwait <= lf[3:2];
        raddr <= mem_addr;
      end
    end
  end

  // per-clock access monitor against the reference sequence
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_gnt) begin
      if (exp_q.size() == 0) check("R9", "unexpected access addr", mem_addr, 0);
      else begin
        acc_t a;
        a = exp_q.pop_front();
        check(a.tag, "access we", mem_we, a.we);
        check(a.tag, "access addr", mem_addr, a.addr);
        if (a.we) check("R7", "writeback data", mem_wdata, a.data);
      end
    end
    if (rst_n && chk_valid) begin
      check("R6", "chk_valid expected", exp_leaf_v, 1);
      check("R6", "chk_pte", chk_pte, exp_leaf);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL R13 watchdog expired actual=%0d expected<=150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  bit [35:0] e_pa;
  bit [1:0]  e_size;
  bit [9:0]  e_err;
  bit [31:0] e_pte;
  bit [2:0]  e_rights;

  task automatic model(bit [31:0] va, bit st, bit fe, bit pr, bit [1:0] pl, bit [2:0] flt,
                       bit byp, bit bt, bit [7:0] cx);
    longint a;
    int lvl;
    bit [31:0] e;
    e_pa = 0; e_size = 0; e_err = 0; e_pte = 0; e_rights = 0; exp_leaf_v = 0;
    if (byp) begin
      if (fe && bt) begin e_pa = rom_base | {17'h0, va[18:0]}; e_rights = 3'b101; end
      else begin e_pa = {4'h0, va}; e_rights = 3'b111; end
      return;
    end
    a = ({4'h0, ctp} << 4) + cx * 4;
    lvl = 0;
    forever begin
      e = rd(a[35:0]);
      exp_q.push_back('{0, a[35:0], 0, "R2"});
      if (pr) begin
        if (e[1:0] == 2 && lvl > 0) begin e_pte = e; return; end
        if (!(e[1:0] == 1 && lvl < 3)) begin e_pte = 0; return; end
        if (lvl == pl) begin e_pte = e; return; end
      end else begin
        if (e[1:0] == 0) begin e_err = 10'((lvl << 8) | (1 << 2)); return; end
        if (e[1:0] == 2 && lvl > 0) break;
        if (!(e[1:0] == 1 && lvl < 3)) begin e_err = 10'((lvl << 8) | (4 << 2)); return; end
      end
      lvl++;
      a = longint'({e[31:2], 2'b00}) << 4;
      case (lvl)
        1: a += va[31:24] * 4;
        2: a += va[23:18] * 4;
        default: a += va[17:12] * 4;
      endcase
    end
    exp_leaf = e; exp_leaf_v = 1;
    if (flt != 0) begin e_err = 10'((lvl << 8) | (flt << 2)); return; end
    case (lvl)
      1: begin e_size = 2; e_pa = 36'((longint'(e[31:8]) << 12) + va[23:0]); end
      2: begin e_size = 1; e_pa = 36'((longint'(e[31:8]) << 12) + va[17:0]); end
      default: begin e_size = 0; e_pa = 36'((longint'(e[31:8]) << 12) + va[11:0]); end
    endcase
    e_pte = e | 32'h20 | (st ? 32'h40 : 32'h0);
    if (e_pte != e) exp_q.push_back('{1, a[35:0], e_pte, "R7"});
  endtask

  task automatic run(string tag, bit [31:0] va, bit st, bit fe, bit pr, bit [1:0] pl,
                     bit [2:0] flt, bit byp, bit bt, bit [7:0] cx);
    int n;
    model(va, st, fe, pr, pl, flt, byp, bt, cx);
    @(negedge clk);
    req_va = va; req_store = st; req_fetch = fe; req_probe = pr; req_level = pl;
    chk_fault = flt; bypass = byp; boot = bt; ctx = cx;
    check("R13", "ready before request", req_ready, 1);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 500) begin @(negedge clk); n++; end
    check("R13", "done seen", done, 1);
    check(tag, "err", err, e_err);
    if (e_err == 0) begin
      check(tag, "pte", pte, e_pte);
      if (!pr) begin
        check(tag, "pa", pa, e_pa);
        check(tag, "size", size, e_size);
        check(tag, "rights", rights, e_rights);
      end
    end
    check("R9", "pending accesses left", exp_q.size(), 0);
    exp_q.delete();
    exp_leaf_v = 0;
    @(negedge clk);
    check("R13", "done one cycle", done, 0);
    check("R13", "ready after done", req_ready, 1);
  endtask

  initial begin
    mem[36'h0100_0010] = 32'h0000_0000;  // ctx4 invalid
    mem[36'h0100_0014] = 32'h0020_0001;  // ctx5 -> L1 table 0x0200_0000
    mem[36'h0100_0018] = 32'h0000_0002;  // ctx6 page at context level
    mem[36'h0100_001C] = 32'h0000_0003;  // ctx7 reserved
    mem[36'h0200_0004] = 32'h3000_0002;  // 16M page
    mem[36'h0200_0008] = 32'h0030_0001;  // -> L2 table 0x0300_0000
    mem[36'h0200_000C] = 32'h0000_0003;  // reserved
    mem[36'h0300_0004] = 32'h0123_4522;  // 256K page, R set
    mem[36'h0300_0008] = 32'h0040_0001;  // -> L3 table 0x0400_0000
    mem[36'h0400_0004] = 32'h0ABC_D062;  // 4K page, R and M set
    mem[36'h0400_0008] = 32'h0000_0101;  // pointer at level 3
    mem[36'h0400_000C] = 32'h0555_5502;  // 4K page, flags clear

    #1;
    check("R1", "ready in reset", req_ready, 1);
    check("R1", "done in reset", done, 0);
    check("R1", "mem_req in reset", mem_req, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ready after reset", req_ready, 1);

    run("R10", 32'h8765_4321, 0, 0, 0, 0, 0, 1, 0, 5);
    run("R11", 32'h1234_5678, 0, 1, 0, 0, 0, 1, 1, 5);
    run("R10", 32'h1234_5678, 0, 1, 0, 0, 0, 1, 0, 5);
    run("R11", 32'h0007_FFFF, 1, 0, 0, 0, 0, 1, 1, 5);  // store ignores boot redirect

    run("R5",  32'h01AB_C123, 0, 0, 0, 0, 0, 0, 0, 5);  // 16M, writes R (R7)
    run("R7",  32'h01AB_C123, 1, 0, 0, 0, 0, 0, 0, 5);  // store sets M
    run("R8",  32'h01FF_FFFF, 1, 0, 0, 0, 0, 0, 0, 5);  // R and M set: no write
    run("R5",  32'h0206_5678, 0, 0, 0, 0, 0, 0, 0, 5);  // 256K, R set load: R8
    run("R7",  32'h0206_5678, 1, 0, 0, 0, 0, 0, 0, 5);
    run("R8",  32'h0208_1345, 1, 0, 0, 0, 0, 0, 0, 5);  // 4K, R5
    run("R6",  32'h0208_3ABC, 1, 0, 0, 0, 3, 0, 0, 5);
    run("R7",  32'h0208_3ABC, 0, 0, 0, 0, 0, 0, 0, 5);
    run("R3",  32'h020C_0000, 0, 0, 0, 0, 0, 0, 0, 5);  // invalid at level 2
    run("R3",  32'h0000_1000, 0, 0, 0, 0, 0, 0, 0, 5);  // invalid at level 1
    run("R3",  32'h0000_1000, 0, 0, 0, 0, 0, 0, 0, 4);  // invalid context
    run("R4",  32'h0300_0000, 0, 0, 0, 0, 0, 0, 0, 5);  // reserved at level 1
    run("R4",  32'h0000_0000, 0, 0, 0, 0, 0, 0, 0, 6);  // page in context table
    run("R4",  32'h0000_0000, 0, 0, 0, 0, 0, 0, 0, 7);  // reserved context entry
    run("R4",  32'h0208_2000, 0, 0, 0, 0, 0, 0, 0, 5);  // pointer at level 3

    for (int l = 0; l < 4; l++) run("R12", 32'h0208_1345, 0, 0, 1, 2'(l), 0, 0, 0, 5);
    run("R12", 32'h01AB_C123, 0, 0, 1, 2, 0, 0, 0, 5);
    run("R12", 32'h0000_0000, 0, 0, 1, 3, 0, 0, 0, 6);
    run("R12", 32'h0300_0000, 0, 0, 1, 3, 0, 0, 0, 5);
    run("R12", 32'h0208_2000, 0, 0, 1, 3, 0, 0, 0, 5);

    for (int i = 0; i < 16; i++) begin
      bit [31:0] v;
      case ($urandom % 4)
        0: v = {8'h01, 24'($urandom)};
        1: v = {14'h0081, 18'($urandom)};
        2: v = {20'h02081, 12'($urandom)};
        default: v = {20'h02083, 12'($urandom)};
      endcase
      run("R2", v, 1'($urandom), 0, 0, 0, 0, 0, 0, 5);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule